// File: doc/BRIEF.md
# Virtualization-Aware Interrupt Selector

This block decides which interrupt a hart should take next. Each cycle it looks at the raised interrupt lines, the per-line enable mask, the delegation mask, the current privilege level, whether the hart is running a guest, and three global enable bits. The three bits are for the machine level, the supervisor level, and the hypervisor's own saved supervisor level. It reports whether any interrupt is takeable, the number of the winning line, and whether the winner must be handled by the hypervisor rather than by the guest.

Three lines are reserved for guest-level sources: guest software on line 2, guest timer on line 6 and guest external on line 10. Outside a guest these three lines are never selected. Inside a guest the selector looks first for hypervisor-level work. If any ordinary line survives the hypervisor's enable, that line wins and the force-to-hypervisor flag is raised. Only when none survives do the three guest lines take part in the normal selection.

The winner is always the lowest-numbered line. A log-depth tree finds it. With the pipeline parameter set, which is the default, the result is registered once.

Top module: `virq_select`

## Requirements
- R1: A line contributes only when its pending bit and its enable bit are both 1. Lines 2, 6 and 10 are the guest lines. They are removed from the ordinary set and are never selected while `virt_i` is 0.
- R2: Machine-level (non-delegated) lines are globally enabled when `priv_i` is below 3 (machine), or when `priv_i` is 3 and `m_ie_i` is 1. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R3: Delegated lines are globally enabled when `priv_i` is below 1, or when `priv_i` is 1 and `s_ie_i` is 1. Delegated lines are never taken at machine privilege.
- R4: While `virt_i` is 1, the ordinary set is gated by the hypervisor supervisor enable: `priv_i` below 1, or `priv_i` equal to 1 with `hs_ie_i` set. Any survivor wins regardless of delegation, and `force_hyp_o` is 1.
- R5: While `virt_i` is 1 and no hypervisor line survives, only the guest lines are candidates, and `force_hyp_o` is 0.
- R6: The candidate set is the selected set ANDed with the machine enable on non-delegated lines (`deleg_i` bit 0), ORed with the selected set ANDed with the supervisor enable on delegated lines (`deleg_i` bit 1).
- R7: The output index is the lowest-numbered candidate. When there is no candidate, `sel_valid_o` is 0 and `sel_idx_o` and `force_hyp_o` are 0.
- R8: With `PIPE`=1, the outputs show the result for the inputs present at the previous rising clock edge. Reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Raised interrupt lines |
| en_i | input | 16 | Per-line enable mask |
| deleg_i | input | 16 | 1 = line delegated to supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Hart is executing a guest |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable (live copy) |
| hs_ie_i | input | 1 | Hypervisor's saved supervisor interrupt enable |
| sel_valid_o | output | 1 | An interrupt is takeable |
| sel_idx_o | output | 4 | Number of the selected line |
| force_hyp_o | output | 1 | Winner must trap to the hypervisor |

## Verification
Every result passes through exactly one register, so the outputs for a given input set are due one rising edge after that set is applied. The bench changes inputs on a falling edge and samples on the next falling edge, when the edge in between has captured the new result. One scenario also samples just before that edge, to confirm the previous result is still held. The checker delays its copies of the inputs by the same single stage, so each output is compared with the inputs that produced it.

// File: rtl/vq_pkg.sv
package vq_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // Lines reserved for guest-level sources
    localparam int unsigned GUEST_SW_LINE  = 2;
    localparam int unsigned GUEST_TMR_LINE = 6;
    localparam int unsigned GUEST_EXT_LINE = 10;

endpackage

// File: rtl/vq_gate.sv
// Privilege-based global enable decode for the three enable domains.
module vq_gate
    import vq_pkg::*;
(
    input  priv_e priv_i,
    input  logic  m_ie_i,
    input  logic  s_ie_i,
    input  logic  hs_ie_i,
    output logic  m_en_o,
    output logic  s_en_o,
    output logic  hs_en_o
);
    logic below_m;
    logic below_s;
    logic at_s;

    always_comb begin
        below_m = (priv_i != PRIV_MACH);
        below_s = (priv_i == PRIV_USER);
        at_s    = (priv_i == PRIV_SUPER);
        m_en_o  = below_m || ((priv_i == PRIV_MACH) && m_ie_i);
        s_en_o  = below_s || (at_s && s_ie_i);
        hs_en_o = below_s || (at_s && hs_ie_i);
    end

endmodule

// File: rtl/vq_lowest.sv
// Lowest-set-bit finder built as a binary reduction tree of depth log2(W).
module vq_lowest #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]         vec_i,
    output logic                 any_o,
    output logic [$clog2(W)-1:0] idx_o
);
    localparam int unsigned LV = $clog2(W);
    localparam int unsigned WP = 1 << LV;

    logic [WP-1:0] node_v;
    logic [LV-1:0] node_i [WP];

    always_comb begin
        node_v = '0;
        node_v[W-1:0] = vec_i;
        for (int k = 0; k < WP; k++) begin
            node_i[k] = '0;
        end
        // Each level halves the node count; left child has priority.
        for (int l = 0; l < LV; l++) begin
            for (int k = 0; k < (WP >> (l + 1)); k++) begin
                if (node_v[2*k]) begin
                    node_i[k] = node_i[2*k];
                end else begin
                    node_i[k] = node_i[2*k+1] | LV'(1 << l);
                end
                node_v[k] = node_v[2*k] | node_v[2*k+1];
            end
        end
        any_o = node_v[0];
        idx_o = node_v[0] ? node_i[0] : '0;
    end

endmodule

// File: rtl/virq_select.sv
module virq_select
    import vq_pkg::*;
#(
    parameter int unsigned NIRQ = 16,
    parameter bit          PIPE = 1'b1,
    localparam int unsigned IW  = $clog2(NIRQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    input  logic            hs_ie_i,
    output logic            sel_valid_o,
    output logic [IW-1:0]   sel_idx_o,
    output logic            force_hyp_o
);
    localparam logic [NIRQ-1:0] GMASK =
        (NIRQ'(1) << GUEST_SW_LINE) |
        (NIRQ'(1) << GUEST_TMR_LINE) |
        (NIRQ'(1) << GUEST_EXT_LINE);

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] idx;
        logic          force_hyp;
    } pick_t;

    logic            m_en, s_en, hs_en;
    logic [NIRQ-1:0] live, ord_set, gst_set, hyp_set, use_set, cand;
    logic            hyp_any, cand_any;
    logic [IW-1:0]   hyp_idx, cand_idx;
    pick_t           pick_d;

    vq_gate u_gate (
        .priv_i  (priv_e'(priv_i)),
        .m_ie_i  (m_ie_i),
        .s_ie_i  (s_ie_i),
        .hs_ie_i (hs_ie_i),
        .m_en_o  (m_en),
        .s_en_o  (s_en),
        .hs_en_o (hs_en)
    );

    // Set split and delegation gating
    always_comb begin
        live    = pend_i & en_i;
        ord_set = live & ~GMASK;
        gst_set = live & GMASK;
        hyp_set = virt_i ? (ord_set & {NIRQ{hs_en}}) : '0;
        use_set = virt_i ? gst_set : ord_set;
        cand    = (use_set & ~deleg_i & {NIRQ{m_en}}) |
                  (use_set &  deleg_i & {NIRQ{s_en}});
    end

    // Two trees in parallel keep the hypervisor path off the critical chain
    vq_lowest #(.W(NIRQ)) u_hyp_tree (
        .vec_i (hyp_set),
        .any_o (hyp_any),
        .idx_o (hyp_idx)
    );

    vq_lowest #(.W(NIRQ)) u_cand_tree (
        .vec_i (cand),
        .any_o (cand_any),
        .idx_o (cand_idx)
    );

    always_comb begin
        pick_d = '0;
        if (hyp_any) begin
            pick_d.valid     = 1'b1;
            pick_d.idx       = hyp_idx;
            pick_d.force_hyp = 1'b1;
        end else if (cand_any) begin
            pick_d.valid     = 1'b1;
            pick_d.idx       = cand_idx;
        end
    end

    generate
        if (PIPE) begin : g_reg
            pick_t pick_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pick_q <= '0;
                end else begin
                    pick_q <= pick_d;
                end
            end
            assign sel_valid_o = pick_q.valid;
            assign sel_idx_o   = pick_q.idx;
            assign force_hyp_o = pick_q.force_hyp;
        end else begin : g_comb
            assign sel_valid_o = pick_d.valid;
            assign sel_idx_o   = pick_d.idx;
            assign force_hyp_o = pick_d.force_hyp;
        end
    endgenerate

endmodule

// File: rtl/virq_select_chk.sv
module virq_select_chk
    import vq_pkg::*;
#(
    parameter int unsigned NIRQ = 16,
    parameter bit          PIPE = 1'b1,
    localparam int unsigned IW  = $clog2(NIRQ)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NIRQ-1:0] pend_i,
    input logic [NIRQ-1:0] en_i,
    input logic [NIRQ-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            virt_i,
    input logic            m_ie_i,
    input logic            s_ie_i,
    input logic            hs_ie_i,
    input logic            sel_valid_o,
    input logic [IW-1:0]   sel_idx_o,
    input logic            force_hyp_o
);
    localparam logic [NIRQ-1:0] GM =
        (NIRQ'(1) << GUEST_SW_LINE) |
        (NIRQ'(1) << GUEST_TMR_LINE) |
        (NIRQ'(1) << GUEST_EXT_LINE);

    logic [NIRQ-1:0] live_d;
    logic [1:0]      priv_d;
    logic            virt_d, mie_d;

    generate
        if (PIPE) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    live_d <= '0;
                    priv_d <= '0;
                    virt_d <= 1'b0;
                    mie_d  <= 1'b0;
                end else begin
                    live_d <= pend_i & en_i;
                    priv_d <= priv_i;
                    virt_d <= virt_i;
                    mie_d  <= m_ie_i;
                end
            end
        end else begin : g_now
            assign live_d = pend_i & en_i;
            assign priv_d = priv_i;
            assign virt_d = virt_i;
            assign mie_d  = m_ie_i;
        end
    endgenerate

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_idx_o == '0 && !force_hyp_o)); // R7
    AST_PICK_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> live_d[sel_idx_o]); // R6
    AST_FORCE_NEEDS_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
        force_hyp_o |-> virt_d); // R4
    AST_GUEST_NEEDS_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && !virt_d) |-> !GM[sel_idx_o]); // R1
    AST_M_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_d == 2'd3 && !mie_d) |-> !sel_valid_o); // R2
    AST_GUEST_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && GM[sel_idx_o]) |-> !force_hyp_o); // R5

endmodule

bind virq_select virq_select_chk #(.NIRQ(NIRQ), .PIPE(PIPE)) u_chk (.*);

// File: tb/virq_select_bench.sv
module virq_select_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pend_i = '0, en_i = '0, deleg_i = '0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0, m_ie_i = 1'b0, s_ie_i = 1'b0, hs_ie_i = 1'b0;
    logic        sel_valid_o, force_hyp_o;
    logic [3:0]  sel_idx_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    virq_select u_virq_select (
        .clk, .rst_n, .pend_i, .en_i, .deleg_i, .priv_i, .virt_i,
        .m_ie_i, .s_ie_i, .hs_ie_i, .sel_valid_o, .sel_idx_o, .force_hyp_o
    );

    task automatic chk(input string req, input logic ev, input logic [3:0] ei, input logic ef);
        n_chk++;
        if (sel_valid_o !== ev || sel_idx_o !== ei || force_hyp_o !== ef) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b idx=%0d force=%0b, expected valid=%0b idx=%0d force=%0b",
                     req, sel_valid_o, sel_idx_o, force_hyp_o, ev, ei, ef);
        end
    endtask

    // Drive on a falling edge; result is due after the next rising edge.
    task automatic apply(input logic [15:0] p, input logic [15:0] e, input logic [15:0] d,
                         input logic [1:0] pr, input logic v, input logic mi,
                         input logic si, input logic hi);
        @(negedge clk);
        pend_i = p; en_i = e; deleg_i = d; priv_i = pr;
        virt_i = v; m_ie_i = mi; s_ie_i = si; hs_ie_i = hi;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R8 reset", 1'b0, 4'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset released idle", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_machine_gate();
        apply(16'h0880, 16'hffff, 16'h0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 machine enabled lowest=7", 1'b1, 4'd7, 1'b0);
        apply(16'h0880, 16'hffff, 16'h0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 machine disabled at M", 1'b0, 4'd0, 1'b0);
        apply(16'h0008, 16'hffff, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 user priv enables machine lines", 1'b1, 4'd3, 1'b0);
    endtask

    task automatic t_enable_and_guest();
        apply(16'h0028, 16'h0020, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 disabled line skipped", 1'b1, 4'd5, 1'b0);
        apply(16'h0444, 16'hffff, 16'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R1 guest lines ignored outside guest", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_delegation();
        apply(16'h0200, 16'hffff, 16'h0200, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 delegated blocked at S with s_ie=0", 1'b0, 4'd0, 1'b0);
        apply(16'h0200, 16'hffff, 16'h0200, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 delegated taken at S with s_ie=1", 1'b1, 4'd9, 1'b0);
        apply(16'h0200, 16'hffff, 16'h0200, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R3 delegated never at M", 1'b0, 4'd0, 1'b0);
        apply(16'h0202, 16'hffff, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 split picks non-delegated 9", 1'b1, 4'd9, 1'b0);
    endtask

    task automatic t_hypervisor_wins();
        apply(16'h0060, 16'hffff, 16'h0020, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R4 hypervisor line 5 wins with force", 1'b1, 4'd5, 1'b1);
        apply(16'h0200, 16'hffff, 16'h0200, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4 guest-user priv forces hypervisor", 1'b1, 4'd9, 1'b1);
    endtask

    task automatic t_guest_path();
        apply(16'h0442, 16'hffff, 16'h0440, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 guest line 6 without force", 1'b1, 4'd6, 1'b0);
        apply(16'h0442, 16'hffff, 16'h0040, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 R6 guest line 10 via machine enable", 1'b1, 4'd10, 1'b0);
        apply(16'h0002, 16'hffff, 16'h0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R5 non-guest line not a guest candidate", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_priority();
        apply(16'h8000, 16'hffff, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 top line alone", 1'b1, 4'd15, 1'b0);
        apply(16'hffff, 16'hffff, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 all lines lowest=0", 1'b1, 4'd0, 1'b0);
    endtask

    task automatic t_latency();
        apply(16'h0010, 16'hffff, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 settle", 1'b1, 4'd4, 1'b0);
        @(negedge clk);
        pend_i = 16'h1000;
        #1;
        chk("R8 old result held before edge", 1'b1, 4'd4, 1'b0);
        @(negedge clk);
        chk("R8 new result after one edge", 1'b1, 4'd12, 1'b0);
    endtask

    initial begin
        t_reset();
        t_machine_gate();
        t_enable_and_guest();
        t_delegation();
        t_hypervisor_wins();
        t_guest_path();
        t_priority();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule